// File: doc/BRIEF.md
# Burst Address Generator with Selectable Order

This block supplies the word address for a synchronous memory array. It holds a base address and a 2-bit beat count. The low two bits of the outgoing address walk through a burst of up to four words, and the upper bits come straight from the base. Two independent load strobes each capture a fresh external address. An advance input steps the burst by one beat. A mode input chooses how the low bits move: a wrapping add, or an XOR of the start bits with the beat count.

A controller may use bursts or skip them. It can present a new address on every clock edge at full rate, or load once and then advance through the remaining words of the four-word block. The burst never carries into the upper address bits. Every input is captured on the rising clock edge, the mode input included. The address output is driven from registered state, so it changes one edge after the inputs that cause the change.

Top module: `burstAddrGen`

## Requirements
- R1: While `rstN` is low, and after reset before any load, `addrOut` is all zeros and the order register holds interleaved mode.
- R2: A rising edge with `loadA` high captures `addrIn`. After that edge `addrOut` equals the captured address and the beat count is zero.
- R3: A rising edge with `loadB` high captures `addrIn` in the same way as `loadA`.
- R4: When `loadA` and `loadB` are both high on an edge, that edge is one load. A load also wins over `advance`, so the beat count restarts at zero.
- R5: On an edge with no load and `advance` high, the beat count rises by one modulo 4. With no load and `advance` low, `addrOut` does not change.
- R6: With the sampled `orderSel` at 0 (linear), `addrOut[1:0]` = (start low bits + beat count) mod 4.
- R7: With the sampled `orderSel` at 1 (interleaved), `addrOut[1:0]` = start low bits XOR beat count.
- R8: After four advances the address returns to the start word. Between loads, `addrOut[ADDR_W-1:2]` never changes.
- R9: Loads on consecutive edges each appear on `addrOut` after their own edge, with no lost cycle.
- R10: `orderSel` is captured only on a rising edge. A change between edges leaves `addrOut` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadA | input | 1 | First address-load strobe |
| loadB | input | 1 | Second address-load strobe |
| advance | input | 1 | Step the burst by one beat |
| orderSel | input | 1 | 0 = linear wrap, 1 = interleaved XOR |
| addrIn | input | ADDR_W | External word address |
| addrOut | output | ADDR_W | Word address to the array |

## Verification
The bench walks bursts from different start offsets in both orders, past the fourth beat. A counter that carried into the upper bits, or that failed to wrap, would show up there as a wrong block address. It drives both strobes together with `advance`. A design that let `advance` win, or that took only one strobe, would produce a stepped address instead of the loaded one. It also switches `orderSel` between edges and loads on consecutive cycles. These catch a combinational mode path, which would move the address early, and a load that needs an extra cycle, which would lag by one vector.

// File: rtl/burstAddrPkg.sv
package burstAddrPkg;
  localparam int BURST_W = 2;
  localparam int BEATS   = 1 << BURST_W;

  typedef struct packed {
    logic               load;
    logic               step;
    logic [BURST_W-1:0] beat;
  } burstCtrlT;
endpackage

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstAddrPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadA,
  input  logic      loadB,
  input  logic      advance,
  output burstCtrlT ctrlOut
);
  logic               loadReq;
  logic               stepReq;
  logic [BURST_W-1:0] beatQ;

  assign loadReq = loadA | loadB;
  assign stepReq = advance & ~loadReq;

  always_ff @(posedge clk) begin
    if (!rstN)        beatQ <= '0;
    else if (loadReq) beatQ <= '0;
    else if (stepReq) beatQ <= beatQ + 1'b1;
  end

  always_comb begin
    ctrlOut.load = loadReq;
    ctrlOut.step = stepReq;
    ctrlOut.beat = beatQ;
  end

  // R4
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadA && loadB && advance) |=> (beatQ == '0));
  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadA && !loadB && advance) |=> (beatQ == BURST_W'($past(beatQ) + 1'b1)));
  // R5
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadA && !loadB && !advance) |=> $stable(beatQ));
endmodule

// File: rtl/burstDatapath.sv
module burstDatapath
  import burstAddrPkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtrlT         ctrlIn,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseQ;
  logic               orderQ;
  logic [BURST_W-1:0] startLow;
  logic [BURST_W-1:0] linLow;
  logic [BURST_W-1:0] ilvLow;
  logic [UPPER_W-1:0] upperBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      orderQ <= 1'b1;
    end else begin
      orderQ <= orderSel;
      if (ctrlIn.load) baseQ <= addrIn;
    end
  end

  assign startLow  = baseQ[BURST_W-1:0];
  assign upperBits = baseQ[ADDR_W-1:BURST_W];
  assign linLow    = startLow + ctrlIn.beat;
  assign ilvLow    = startLow ^ ctrlIn.beat;
  assign addrOut   = {upperBits, (orderQ ? ilvLow : linLow)};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.load |=> (addrOut == $past(addrIn)));
  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.load |=> $stable(addrOut[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/burstAddrGen.sv
module burstAddrGen
  import burstAddrPkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadA,
  input  logic              loadB,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  burstCtrlT ctrlBus;

  burstCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .loadA   (loadA),
    .loadB   (loadB),
    .advance (advance),
    .ctrlOut (ctrlBus)
  );

  burstDatapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .orderSel (orderSel),
    .addrIn   (addrIn),
    .addrOut  (addrOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (addrOut == '0));
endmodule

// File: tb/burstAddrGen_tb.sv
module burstAddrGen_tb_top;
  localparam int AW = 21;
  localparam int NV = 17;
  localparam int VW = 4 + 2 * AW;

  // vector: {loadA, loadB, advance, orderSel, addrIn, expected addrOut}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b1000, 21'h12345, 21'h12345},  // R2 load, linear
    {4'b0010, 21'h00000, 21'h12346},  // R6
    {4'b0010, 21'h00000, 21'h12347},  // R6
    {4'b0010, 21'h00000, 21'h12344},  // R8 wrap, no carry
    {4'b0010, 21'h00000, 21'h12345},  // R8 back to start
    {4'b0000, 21'h00000, 21'h12345},  // R5 hold
    {4'b0101, 21'h0ABCE, 21'h0ABCE},  // R3 load, interleaved
    {4'b0011, 21'h00000, 21'h0ABCF},  // R7
    {4'b0011, 21'h00000, 21'h0ABCC},  // R7
    {4'b0011, 21'h00000, 21'h0ABCD},  // R7
    {4'b0011, 21'h00000, 21'h0ABCE},  // R8
    {4'b1111, 21'h1FFFF, 21'h1FFFF},  // R4 both strobes + advance
    {4'b0011, 21'h00000, 21'h1FFFE},  // R7
    {4'b0010, 21'h00000, 21'h1FFFD},  // R10 order switched at edge
    {4'b0110, 21'h00000, 21'h00000},  // R4 load beats advance
    {4'b1000, 21'h1FFFC, 21'h1FFFC},  // R9 back-to-back
    {4'b0100, 21'h00003, 21'h00003}   // R9 back-to-back
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadA = 1'b0, loadB = 1'b0, advance = 1'b0, orderSel = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burstAddrGen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .loadA(loadA), .loadB(loadB),
    .advance(advance), .orderSel(orderSel), .addrIn(addrIn), .addrOut(addrOut)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addrOut !== exp) begin
      bad++;
      $display("FAIL %s: addrOut=%h expected=%h", req, addrOut, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ctl, input logic [AW-1:0] a);
    @(negedge clk);
    {loadA, loadB, advance, orderSel} = ctl;
    addrIn = a;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", '0);  // in reset
    @(negedge clk);
    rstN = 1'b1;
    drive(4'b0001, 21'h00000);
    check("R1", '0);  // after reset, no load
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][VW-1:VW-4], VEC[i][2*AW-1:AW]);
      check($sformatf("vec%0d R2-R9", i), VEC[i][AW-1:0]);
    end
    // R10: order change between edges has no effect until the next edge
    drive(4'b1000, 21'h00001);
    drive(4'b0010, 21'h00000);
    check("R6", 21'h00002);
    @(negedge clk);
    advance = 1'b0;
    orderSel = 1'b1;
    #1;
    check("R10", 21'h00002);
    @(posedge clk);
    #2;
    check("R10", 21'h00000);
    // R1: mid-run reset
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #2;
    check("R1", '0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule